// File: doc/BRIEF.md
# Banked GPIO Port Register File

This block is a memory-mapped general-purpose I/O port for a parameterized number of pins (36 by default, 30 in a second common configuration). Each pin has an output-enable bit, an output-value bit, a free control bit and a sampled input bit. Each of these four functions is stored as a pair of 32-bit words. Pins 0 to 31 sit in the low word of a pair. Pins 32 and up sit in the high word, which lies 4 bytes above the low word.

Software reaches the port over a simple synchronous register bus: a byte address, a write enable, write data and registered read data. The pad side receives the output value, the output enable and a per-pin control vector straight from storage. The raw pin levels come back through a two-flop synchronizer before software can read them.

Top module: `gpio_bank_regs`

## Requirements
- R1: While reset is asserted, every output-enable, output-value and control bit is 0, and bus_rdata is 0. Every pin therefore starts as an input.
- R2: The output-enable pair sits at byte offsets 0x00 (low) and 0x04 (high). A stored 1 makes pad_oe for that pin 1 (output), and a 0 makes it 0 (input). pad_oe follows a write from the clock edge that accepts it.
- R3: The output-value pair sits at 0x18 and 0x1C. pad_out follows a write from the clock edge that accepts it, and reads return the stored value.
- R4: The control pair sits at 0x20 and 0x24. It is plain read/write storage, exported bit for bit on pad_ctl.
- R5: Pin i with i < 32 is bit i of the low word. Pin i with i >= 32 is bit (i - 32) of the high word at the low offset + 4.
- R6: The input pair at 0x10 and 0x14 is read-only. Writes to it change nothing. It returns the level of every pin whatever its direction, through a two-stage synchronizer, so a pin change made before clock edge k appears on bus_rdata after edge k+2.
- R7: bus_rdata is registered. After a clock edge it holds the word addressed when that edge occurred.
- R8: Bits of a word that belong to pins at or above NUM_PINS read as 0, and writes to them are dropped.
- R9: Any byte address other than the eight mapped word addresses (including unaligned ones) reads as 0, and writes to it change no state.
- R10: Output-enable, output-value and control bits keep their value on every edge without a write to their own word.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | ADDR_W | Byte address of the accessed word |
| bus_we | input | 1 | Write strobe, sampled on the rising clock edge |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| pin_in | input | NUM_PINS | Raw pin levels from the pads |
| pad_out | output | NUM_PINS | Output value per pin |
| pad_oe | output | NUM_PINS | Output enable per pin, 1 drives the pin |
| pad_ctl | output | NUM_PINS | Per-pin control vector |

## Verification
Pad outputs change on the same edge that accepts a write. The bench therefore drives each write at a falling edge and compares pad_oe, pad_out and pad_ctl one time step after the next rising edge. A read is presented at a falling edge, and its data is compared just after the following rising edge, which matches the one-cycle registered read. A pin change reaches a read only after two further edges. The bench waits three rising edges after each pin change before any input read, so the expected input word is always the settled one. Random writes and reads over mapped, unmapped and unaligned addresses are compared against a word-level model of the register pairs.

// File: rtl/gpio_bank_pkg.sv
`timescale 1ns/1ps
package gpio_bank_pkg;

   // register word width seen by software
   localparam int unsigned WORD_W   = 32;
   // widest port the pair layout can hold
   localparam int unsigned MAX_PINS = 2 * WORD_W;

   // function slots; order is the storage index
   localparam int unsigned NUM_FN   = 4;
   localparam int unsigned FN_IDX_W = $clog2(NUM_FN);
   localparam int unsigned FN_OE    = 0;
   localparam int unsigned FN_IN    = 1;
   localparam int unsigned FN_OUT   = 2;
   localparam int unsigned FN_CTL   = 3;

   // byte offset of the low word of each function
   localparam int unsigned OFF_OE   = 'h00;
   localparam int unsigned OFF_IN   = 'h10;
   localparam int unsigned OFF_OUT  = 'h18;
   localparam int unsigned OFF_CTL  = 'h20;
   // distance from low word to high word
   localparam int unsigned HI_STEP  = 4;

   // which slots software may write
   localparam logic [NUM_FN-1:0] FN_WRITABLE = 4'b1101;

   function automatic int unsigned fn_base(input int unsigned fn);
      case (fn)
         FN_OE:   return OFF_OE;
         FN_IN:   return OFF_IN;
         FN_OUT:  return OFF_OUT;
         default: return OFF_CTL;
      endcase
   endfunction

   // select one 32-bit half of a zero-extended 64-bit pin vector
   function automatic logic [WORD_W-1:0] pick_word(input logic [MAX_PINS-1:0] v,
                                                   input logic hi);
      return hi ? v[MAX_PINS-1:WORD_W] : v[WORD_W-1:0];
   endfunction

endpackage

// File: rtl/gpio_bank_sync.sv
`timescale 1ns/1ps
module gpio_bank_sync #(
   parameter int unsigned WIDTH  = 36,
   parameter int unsigned STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] q
);

   if (STAGES < 2) begin : g_bad_stages
      $error("gpio_bank_sync: STAGES must be at least 2");
   end

   logic [WIDTH-1:0] chain [STAGES];

   for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain[s] <= '0;
            else        chain[s] <= d;
         end
      end else begin : g_next
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain[s] <= '0;
            else        chain[s] <= chain[s-1];
         end
      end
   end

   assign q = chain[STAGES-1];

endmodule

// File: rtl/gpio_bank_pair.sv
`timescale 1ns/1ps
module gpio_bank_pair
   import gpio_bank_pkg::*;
#(
   parameter int unsigned NUM_PINS = 36
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                wr_lo,
   input  logic                wr_hi,
   input  logic [WORD_W-1:0]   wdata,
   output logic [NUM_PINS-1:0] q
);

   // each pin lands in the low or high word depending on its index
   for (genvar i = 0; i < NUM_PINS; i++) begin : g_bit
      localparam int unsigned POS = i % WORD_W;
      if (i < WORD_W) begin : g_low
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)     q[i] <= 1'b0;
            else if (wr_lo) q[i] <= wdata[POS];
         end
      end else begin : g_high
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)     q[i] <= 1'b0;
            else if (wr_hi) q[i] <= wdata[POS];
         end
      end
   end

   // high-word strobe is unused when all pins fit in one word
   if (NUM_PINS <= WORD_W) begin : g_no_high
      logic unused_hi;
      assign unused_hi = wr_hi;
   end

endmodule

// File: rtl/gpio_bank_decode.sv
`timescale 1ns/1ps
module gpio_bank_decode
   import gpio_bank_pkg::*;
#(
   parameter int unsigned ADDR_W = 8
) (
   input  logic [ADDR_W-1:0]   addr,
   input  logic                we,
   output logic                rd_valid,
   output logic [FN_IDX_W-1:0] rd_idx,
   output logic                rd_hi,
   output logic [NUM_FN-1:0]   wr_lo,
   output logic [NUM_FN-1:0]   wr_hi
);

   logic [NUM_FN-1:0] hit_lo;
   logic [NUM_FN-1:0] hit_hi;

   // exact match against the low and high word address of each slot
   for (genvar f = 0; f < NUM_FN; f++) begin : g_fn
      localparam logic [ADDR_W-1:0] A_LO = ADDR_W'(fn_base(f));
      localparam logic [ADDR_W-1:0] A_HI = ADDR_W'(fn_base(f) + HI_STEP);
      assign hit_lo[f] = (addr == A_LO);
      assign hit_hi[f] = (addr == A_HI);
      if (FN_WRITABLE[f]) begin : g_wr
         assign wr_lo[f] = we & hit_lo[f];
         assign wr_hi[f] = we & hit_hi[f];
      end else begin : g_ro
         assign wr_lo[f] = 1'b0;
         assign wr_hi[f] = 1'b0;
      end
   end

   always_comb begin
      rd_valid = 1'b0;
      rd_idx   = '0;
      rd_hi    = 1'b0;
      for (int f = 0; f < NUM_FN; f++) begin
         if (hit_lo[f] || hit_hi[f]) begin
            rd_valid = 1'b1;
            rd_idx   = FN_IDX_W'(f);
            rd_hi    = hit_hi[f];
         end
      end
   end

endmodule

// File: rtl/gpio_bank_regs.sv
`timescale 1ns/1ps
module gpio_bank_regs
   import gpio_bank_pkg::*;
#(
   parameter int unsigned NUM_PINS    = 36,
   parameter int unsigned ADDR_W      = 8,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [ADDR_W-1:0]   bus_addr,
   input  logic                bus_we,
   input  logic [WORD_W-1:0]   bus_wdata,
   output logic [WORD_W-1:0]   bus_rdata,
   input  logic [NUM_PINS-1:0] pin_in,
   output logic [NUM_PINS-1:0] pad_out,
   output logic [NUM_PINS-1:0] pad_oe,
   output logic [NUM_PINS-1:0] pad_ctl
);

   // elaboration-time parameter checks
   if (NUM_PINS < 1 || NUM_PINS > MAX_PINS) begin : g_bad_pins
      $error("gpio_bank_regs: NUM_PINS must lie in 1..64");
   end
   if ((1 << ADDR_W) < (OFF_CTL + HI_STEP + 4)) begin : g_bad_addr
      $error("gpio_bank_regs: ADDR_W too narrow for the register map");
   end

   logic                rd_valid;
   logic [FN_IDX_W-1:0] rd_idx;
   logic                rd_hi;
   logic [NUM_FN-1:0]   wr_lo;
   logic [NUM_FN-1:0]   wr_hi;
   logic [NUM_PINS-1:0] fn_q [NUM_FN];
   logic [NUM_PINS-1:0] pin_sync;

   gpio_bank_decode #(
      .ADDR_W (ADDR_W)
   ) u_decode (
      .addr     (bus_addr),
      .we       (bus_we),
      .rd_valid (rd_valid),
      .rd_idx   (rd_idx),
      .rd_hi    (rd_hi),
      .wr_lo    (wr_lo),
      .wr_hi    (wr_hi)
   );

   gpio_bank_sync #(
      .WIDTH  (NUM_PINS),
      .STAGES (SYNC_STAGES)
   ) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (pin_in),
      .q     (pin_sync)
   );

   // writable slots get storage, the read-only slot shows the synchronized pins
   for (genvar f = 0; f < NUM_FN; f++) begin : g_slot
      if (FN_WRITABLE[f]) begin : g_store
         gpio_bank_pair #(
            .NUM_PINS (NUM_PINS)
         ) u_pair (
            .clk   (clk),
            .rst_n (rst_n),
            .wr_lo (wr_lo[f]),
            .wr_hi (wr_hi[f]),
            .wdata (bus_wdata),
            .q     (fn_q[f])
         );
      end else begin : g_input
         assign fn_q[f] = pin_sync;
         logic unused_wr;
         assign unused_wr = wr_lo[f] | wr_hi[f];
      end
   end

   // registered read port; absent pins read as zero through the zero extension
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        bus_rdata <= '0;
      else if (rd_valid) bus_rdata <= pick_word(MAX_PINS'(fn_q[rd_idx]), rd_hi);
      else               bus_rdata <= '0;
   end

   assign pad_oe  = fn_q[FN_OE];
   assign pad_out = fn_q[FN_OUT];
   assign pad_ctl = fn_q[FN_CTL];

endmodule

// File: rtl/gpio_bank_regs_chk.sv
`timescale 1ns/1ps
module gpio_bank_regs_chk
   import gpio_bank_pkg::*;
#(
   parameter int unsigned NUM_PINS = 36,
   parameter int unsigned ADDR_W   = 8
) (
   input logic                clk,
   input logic                rst_n,
   input logic [ADDR_W-1:0]   bus_addr,
   input logic                bus_we,
   input logic [WORD_W-1:0]   bus_wdata,
   input logic [WORD_W-1:0]   bus_rdata,
   input logic [NUM_PINS-1:0] pad_out,
   input logic [NUM_PINS-1:0] pad_oe,
   input logic [NUM_PINS-1:0] pad_ctl
);

   localparam logic [MAX_PINS-1:0] PIN_MASK =
      (NUM_PINS >= MAX_PINS) ? '1 : ((64'd1 << NUM_PINS) - 64'd1);
   localparam logic [WORD_W-1:0] LO_MASK = PIN_MASK[WORD_W-1:0];
   localparam logic [WORD_W-1:0] HI_MASK = PIN_MASK[MAX_PINS-1:WORD_W];

   localparam logic [ADDR_W-1:0] A_OE_LO  = ADDR_W'(OFF_OE);
   localparam logic [ADDR_W-1:0] A_OE_HI  = ADDR_W'(OFF_OE + HI_STEP);
   localparam logic [ADDR_W-1:0] A_IN_LO  = ADDR_W'(OFF_IN);
   localparam logic [ADDR_W-1:0] A_IN_HI  = ADDR_W'(OFF_IN + HI_STEP);
   localparam logic [ADDR_W-1:0] A_OUT_LO = ADDR_W'(OFF_OUT);
   localparam logic [ADDR_W-1:0] A_OUT_HI = ADDR_W'(OFF_OUT + HI_STEP);
   localparam logic [ADDR_W-1:0] A_CTL_LO = ADDR_W'(OFF_CTL);
   localparam logic [ADDR_W-1:0] A_CTL_HI = ADDR_W'(OFF_CTL + HI_STEP);

   logic is_lo, is_hi, is_oe, is_out, is_ctl;
   assign is_lo  = (bus_addr == A_OE_LO) || (bus_addr == A_IN_LO) ||
                   (bus_addr == A_OUT_LO) || (bus_addr == A_CTL_LO);
   assign is_hi  = (bus_addr == A_OE_HI) || (bus_addr == A_IN_HI) ||
                   (bus_addr == A_OUT_HI) || (bus_addr == A_CTL_HI);
   assign is_oe  = (bus_addr == A_OE_LO) || (bus_addr == A_OE_HI);
   assign is_out = (bus_addr == A_OUT_LO) || (bus_addr == A_OUT_HI);
   assign is_ctl = (bus_addr == A_CTL_LO) || (bus_addr == A_CTL_HI);

   // R1: reset clears pads and read data
   a_r1_reset_clear: assert property (@(posedge clk)
      !rst_n |=> (pad_oe == '0) && (pad_out == '0) && (pad_ctl == '0) && (bus_rdata == '0));

   // R2: low output-enable write reaches the pads on the accepting edge
   a_r2_oe_lo_write: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_we && bus_addr == A_OE_LO) |=>
         (WORD_W'(MAX_PINS'(pad_oe)) == ($past(bus_wdata) & LO_MASK)));

   // R5: high output-value word maps to pins 32 and up
   a_r5_out_hi_write: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_we && bus_addr == A_OUT_HI) |=>
         (WORD_W'(MAX_PINS'(pad_out) >> WORD_W) == ($past(bus_wdata) & HI_MASK)));

   // R8: bits of absent pins read as zero
   a_r8_lo_absent_zero: assert property (@(posedge clk) disable iff (!rst_n)
      is_lo |=> ((bus_rdata & ~LO_MASK) == '0));
   a_r8_hi_absent_zero: assert property (@(posedge clk) disable iff (!rst_n)
      is_hi |=> ((bus_rdata & ~HI_MASK) == '0));

   // R9: unmapped addresses read as zero
   a_r9_unmapped_zero: assert property (@(posedge clk) disable iff (!rst_n)
      !(is_lo || is_hi) |=> (bus_rdata == '0));

   // R10: storage holds without a write to its own pair
   a_r10_oe_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !(bus_we && is_oe) |=> $stable(pad_oe));
   a_r10_out_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !(bus_we && is_out) |=> $stable(pad_out));
   a_r10_ctl_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !(bus_we && is_ctl) |=> $stable(pad_ctl));

endmodule

bind gpio_bank_regs gpio_bank_regs_chk #(
   .NUM_PINS (NUM_PINS),
   .ADDR_W   (ADDR_W)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .bus_addr  (bus_addr),
   .bus_we    (bus_we),
   .bus_wdata (bus_wdata),
   .bus_rdata (bus_rdata),
   .pad_out   (pad_out),
   .pad_oe    (pad_oe),
   .pad_ctl   (pad_ctl)
);

// File: tb/gpio_bank_regs_test.sv
`timescale 1ns/1ps
module gpio_bank_regs_test;

   localparam int P  = 36;
   localparam int AW = 8;
   localparam logic [63:0] PM = (64'd1 << P) - 64'd1;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [AW-1:0] bus_addr = '0;
   logic          bus_we = 1'b0;
   logic [31:0]   bus_wdata = '0;
   logic [31:0]   bus_rdata;
   logic [P-1:0]  pin_in = '0;
   logic [P-1:0]  pad_out, pad_oe, pad_ctl;

   always #2.5 clk = ~clk;

   gpio_bank_regs #(.NUM_PINS(P), .ADDR_W(AW)) uut (
      .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pin_in(pin_in),
      .pad_out(pad_out), .pad_oe(pad_oe), .pad_ctl(pad_ctl));

   int n_chk = 0;
   int n_err = 0;
   bit done = 0;

   logic [63:0] m_oe = '0, m_out = '0, m_ctl = '0, m_pins = '0;

   function automatic logic [31:0] exp_rd(input logic [AW-1:0] a);
      case (a)
         8'h00: return m_oe[31:0];
         8'h04: return m_oe[63:32];
         8'h10: return m_pins[31:0];
         8'h14: return m_pins[63:32];
         8'h18: return m_out[31:0];
         8'h1C: return m_out[63:32];
         8'h20: return m_ctl[31:0];
         8'h24: return m_ctl[63:32];
         default: return 32'h0;
      endcase
   endfunction

   task automatic model_write(input logic [AW-1:0] a, input logic [31:0] d);
      case (a)
         8'h00: m_oe[31:0]   = d & PM[31:0];
         8'h04: m_oe[63:32]  = d & PM[63:32];
         8'h18: m_out[31:0]  = d & PM[31:0];
         8'h1C: m_out[63:32] = d & PM[63:32];
         8'h20: m_ctl[31:0]  = d & PM[31:0];
         8'h24: m_ctl[63:32] = d & PM[63:32];
         default: ;
      endcase
   endtask

   task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic check_pads(input string req);
      chk({req, " pad_oe"},  64'(pad_oe),  m_oe);
      chk({req, " pad_out"}, 64'(pad_out), m_out);
      chk({req, " pad_ctl"}, 64'(pad_ctl), m_ctl);
   endtask

   task automatic do_write(input logic [AW-1:0] a, input logic [31:0] d, input string req);
      @(negedge clk);
      bus_addr = a; bus_we = 1'b1; bus_wdata = d;
      @(posedge clk);
      model_write(a, d);
      #1;
      bus_we = 1'b0;
      check_pads(req);
   endtask

   task automatic do_read(input logic [AW-1:0] a, input string req);
      @(negedge clk);
      bus_addr = a; bus_we = 1'b0;
      @(posedge clk);
      #1;
      chk(req, 64'(bus_rdata), 64'(exp_rd(a)));
   endtask

   task automatic set_pins(input logic [63:0] v);
      @(negedge clk);
      pin_in = v[P-1:0];
      m_pins = v & PM;
      repeat (3) @(posedge clk);
   endtask

   localparam logic [AW-1:0] ADDRS [14] = '{8'h00, 8'h04, 8'h10, 8'h14, 8'h18, 8'h1C,
                                            8'h20, 8'h24, 8'h08, 8'h0C, 8'h28, 8'h02,
                                            8'h3C, 8'hFC};

   initial begin
      #(200000 * 5);
      if (!done) begin
         n_chk++; n_err++;
         $display("FAIL watchdog actual=hung expected=finished");
         $display("Result: errors=%0d of %0d checks", n_err, n_chk);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd1234));
      repeat (3) @(posedge clk);
      #1;
      // R1: reset state while held
      chk("R1 rdata in reset", 64'(bus_rdata), 64'h0);
      check_pads("R1");
      @(negedge clk); rst_n = 1'b1;

      // R2 and R5: low and high output enable
      do_write(8'h00, 32'hA5A5_0F0F, "R2 oe low");
      do_write(8'h04, 32'hFFFF_FFFF, "R5 oe high");
      chk("R5 pad_oe pin 35..32", 64'(pad_oe[35:32]), 64'hF);
      do_read(8'h04, "R8 oe high absent bits");
      do_read(8'h00, "R7 oe low readback");
      // R3 output value
      do_write(8'h18, 32'h1234_5678, "R3 out low");
      do_write(8'h1C, 32'h0000_0009, "R3 out high");
      do_read(8'h1C, "R3 out high readback");
      // R10: oe untouched by out writes
      do_read(8'h00, "R10 oe held");
      // R4 control
      do_write(8'h20, 32'hDEAD_BEEF, "R4 ctl low");
      do_write(8'h24, 32'hFFFF_FFF6, "R4 ctl high");
      do_read(8'h24, "R4 ctl high readback");
      // R6 input pair: pins of both directions, write ignored
      set_pins(64'h0000_000A_C3C3_5A5A);
      do_read(8'h10, "R6 in low");
      do_read(8'h14, "R6 in high");
      do_write(8'h10, 32'hFFFF_FFFF, "R6 write ignored pads");
      do_write(8'h14, 32'hFFFF_FFFF, "R6 write ignored pads");
      do_read(8'h10, "R6 in low after write");
      do_read(8'h14, "R6 in high after write");
      // R6 latency: change pins then read after two more edges
      @(negedge clk); pin_in = '1;
      @(posedge clk); @(negedge clk); bus_addr = 8'h10;
      @(posedge clk); #1;
      chk("R6 not yet visible", 64'(bus_rdata), 64'h0000_0000_C3C3_5A5A);
      @(posedge clk); #1;
      chk("R6 visible after sync", 64'(bus_rdata), 64'hFFFF_FFFF);
      m_pins = PM;
      // R9 unmapped and unaligned
      do_write(8'h01, 32'hFFFF_FFFF, "R9 unaligned write no effect");
      do_write(8'h08, 32'h0, "R9 unmapped write no effect");
      do_write(8'h28, 32'h0, "R9 unmapped write no effect");
      do_read(8'h02, "R9 unaligned read");
      do_read(8'h0C, "R9 unmapped read");
      do_read(8'h00, "R9 oe kept");

      // random mix
      for (int it = 0; it < 600; it++) begin
         logic [31:0] r;
         logic [AW-1:0] a;
         r = $urandom;
         a = ADDRS[r[7:4] % 14];
         if (r[0]) do_write(a, $urandom, "R2 R3 R4 random write");
         else      do_read(a, "R7 R8 random read");
         if (it % 37 == 0) set_pins({$urandom, $urandom});
      end

      // R1: reset again clears everything
      @(negedge clk); rst_n = 1'b0;
      m_oe = '0; m_out = '0; m_ctl = '0;
      #1;
      check_pads("R1 second reset");
      chk("R1 rdata second reset", 64'(bus_rdata), 64'h0);

      done = 1;
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end

endmodule